// File: doc/BRIEF.md
# Serial Port Interrupt Status Logic

This block builds the interrupt status for a synchronous serial port that has a transmit FIFO and a receive FIFO. It watches the two FIFO fill levels, a flag that says the output shifter is still busy, done pulses from the transmit and receive DMA channels, and receive overrun and timeout events. From these it keeps a seven-bit raw status word. Some bits follow the FIFO levels. The others are sticky and hold until software clears them by writing ones. A mask register selects which status bits may raise the single interrupt line.

A mode input changes the meaning of the transmit bit. In normal mode the transmit bit asks for more data once the FIFO is half empty. In end-of-transmit mode it is set only when the FIFO is empty and the shifter has sent its final bit, so software learns that the line has gone quiet. Software reaches four words through a small port: raw status, mask, masked status and the write-one-to-clear word. Writes land on the clock edge. Reads are combinational.

Top module: `sport_irq_ctrl`

## Requirements
- R1: Status bit positions are: overrun 0, timeout 1, receive level 2, transmit level 3, receive-DMA done 4, transmit-DMA done 5, end-of-transmit 6. Reset gives a raw word of 0x08.
- R2: With `eot_mode`=0, bit 3 is 1 when the transmit level was at most DEPTH/2 at the previous clock edge, and 0 otherwise.
- R3: With `eot_mode`=1, bit 3 is 1 when, at the previous edge, the transmit level was 0 and `shifter_busy` was 0. Otherwise it is 0.
- R4: Bit 2 is 1 when the receive level was at least DEPTH/2 at the previous edge, and 0 otherwise.
- R5: Bit 6 sets once on each rising edge of the condition "transmit level 0 and shifter idle". It holds until software clears it. The bit does not set again while the condition stays true, and it does not set from the idle state that follows reset.
- R6: Bits 4 and 5 set on `rx_dma_done` and `tx_dma_done` pulses. Each holds until a 1 is written to the same bit position at address 3.
- R7: Bits 0 and 1 set on `rx_overrun` and `rx_timeout` pulses. Each holds until a 1 is written to the same bit position at address 3.
- R8: When a set event and a clearing write hit the same sticky bit in one cycle, the bit ends at 1.
- R9: Writing 1 to bit 2 or bit 3 at address 3 leaves those level bits unchanged.
- R10: Address 1 is a read/write mask that keeps bits 6:0 and resets to 0. Address 2 reads the raw word ANDed with the mask.
- R11: `irq` is 1 exactly when at least one masked status bit is 1.
- R12: Address 0 reads the raw word. Address 3 reads 0. Bits 31:7 of every read are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| shifter_busy | input | 1 | Output shifter still sending a frame |
| eot_mode | input | 1 | 1 selects end-of-transmit meaning of bit 3 |
| tx_dma_done | input | 1 | Transmit DMA completion pulse |
| rx_dma_done | input | 1 | Receive DMA completion pulse |
| rx_overrun | input | 1 | Receive overrun event pulse |
| rx_timeout | input | 1 | Receive timeout event pulse |
| reg_addr | input | 2 | Register word select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data (combinational) |
| irq | output | 1 | Combined masked interrupt |

## Verification
A hardware event that sets a sticky bit can arrive in the same cycle as a software write that clears that bit. The bench provokes this by raising each event pulse together with a write of the matching bit to the clear word. It then reads the raw word and expects the bit to be 1, while the other sticky bits keep their earlier values. A second collision is provoked by writing ones to the clear bits of the level-driven bits while their FIFO conditions hold. The bench then expects those bits to stay unchanged.

// File: rtl/sport_irq_pkg.sv
// Shared constants for the serial port interrupt status logic.
// Assumes a seven-bit status word and a four-word register map.
package sport_irq_pkg;
    localparam int STAT_W = 7;

    // status bit positions (software decodes these)
    localparam int B_OVR = 0;
    localparam int B_TMO = 1;
    localparam int B_RXL = 2;
    localparam int B_TXL = 3;
    localparam int B_RXD = 4;
    localparam int B_TXD = 5;
    localparam int B_EOT = 6;

    // sticky bit count and their slots in the sticky vector
    localparam int N_STICKY = 5;
    localparam int S_OVR = 0;
    localparam int S_TMO = 1;
    localparam int S_RXD = 2;
    localparam int S_TXD = 3;
    localparam int S_EOT = 4;

    // register word select
    localparam logic [1:0] A_RAW  = 2'd0;
    localparam logic [1:0] A_MASK = 2'd1;
    localparam logic [1:0] A_MSTA = 2'd2;
    localparam logic [1:0] A_CLR  = 2'd3;

    // value of the raw word after reset: only the transmit level bit
    localparam logic [STAT_W-1:0] RAW_RST = STAT_W'(1) << B_TXL;

    typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/sport_irq_level.sv
// Level-driven status: registers the transmit and receive level flags
// and detects the end-of-transmit rising edge.
// Assumes levels are valid every cycle and range 0..DEPTH.
module sport_irq_level #(
    parameter int DEPTH = 8,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             shifter_busy,
    input  logic             eot_mode,
    output logic             tx_flag_q,
    output logic             rx_flag_q,
    output logic             eot_pulse
);
    localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);

    logic tx_idle;
    logic idle_prev_q;
    logic tx_flag_d;
    logic rx_flag_d;

    // the line is quiet: nothing queued and the shifter has stopped
    always_comb tx_idle = (tx_level == '0) && !shifter_busy;

    // choose the transmit condition by mode
    always_comb begin
        if (eot_mode) tx_flag_d = tx_idle;
        else          tx_flag_d = (tx_level <= HALF);
    end

    // receive FIFO at or above the half mark
    always_comb rx_flag_d = (rx_level >= HALF);

    // new end-of-transmit only when the quiet condition first appears
    always_comb eot_pulse = tx_idle && !idle_prev_q;

    // level flags; transmit flag resets set, matching an empty FIFO
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flag_q <= 1'b1;
            rx_flag_q <= 1'b0;
        end else begin
            tx_flag_q <= tx_flag_d;
            rx_flag_q <= rx_flag_d;
        end
    end

    // previous quiet state; reset as quiet so reset raises no event
    always_ff @(posedge clk) begin
        if (!rst_n) idle_prev_q <= 1'b1;
        else        idle_prev_q <= tx_idle;
    end

    AST_TX_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!eot_mode && tx_level <= HALF) |=> tx_flag_q); // R2
    AST_TX_NORMAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!eot_mode && tx_level > HALF) |=> !tx_flag_q); // R2
    AST_TX_EOTMODE: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_mode && (tx_level != '0 || shifter_busy)) |=> !tx_flag_q); // R3
    AST_RX_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= HALF) |=> rx_flag_q); // R4
endmodule

// File: rtl/sport_irq_sticky.sv
// Sticky event bits with write-one-to-clear. A set in the same cycle
// as a clear wins. Assumes set and clear strobes last one cycle each.
module sport_irq_sticky #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // hold until cleared; a set event always takes priority
        always_ff @(posedge clk) begin
            if (!rst_n)        q_o[i] <= 1'b0;
            else if (set_i[i]) q_o[i] <= 1'b1;
            else if (clr_i[i]) q_o[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]); // R8
        AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[i] && !clr_i[i]) |=> q_o[i]); // R7
        AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!q_o[i] && !set_i[i]) |=> !q_o[i]); // R6
    end
endmodule

// File: rtl/sport_irq_regs.sv
// Register port: mask storage, clear strobes, read mux and the combined
// interrupt. Assumes single-cycle writes and combinational reads.
module sport_irq_regs
    import sport_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  stat_t             raw_i,
    output stat_t             clr_o,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    stat_t mask_q;
    stat_t masked;
    logic  unused_wdata_hi;

    // upper write bits carry no storage
    always_comb unused_wdata_hi = ^reg_wdata[DATA_W-1:STAT_W];

    // clear strobes pulse only on a write to the clear word
    always_comb clr_o = (reg_wr && reg_addr == A_CLR) ? reg_wdata[STAT_W-1:0] : '0;

    // mask register, written at its own address
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '0;
        else if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[STAT_W-1:0];
    end

    // masked status feeds both the read path and the interrupt
    always_comb masked = raw_i & mask_q;

    // interrupt line: any enabled status bit
    always_comb irq = |masked;

    // read mux; unused upper bits are zero
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RAW:   reg_rdata[STAT_W-1:0] = raw_i;
            A_MASK:  reg_rdata[STAT_W-1:0] = mask_q;
            A_MSTA:  reg_rdata[STAT_W-1:0] = masked;
            default: reg_rdata = '0;
        endcase
    end

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_MASK) |=> $stable(mask_q)); // R10
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:STAT_W] == '0); // R12
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i == '0) |-> !irq); // R11
endmodule

// File: rtl/sport_irq_ctrl.sv
// Top of the serial port interrupt status logic: assembles the raw
// status word from level flags and sticky bits and exposes the
// register port. Assumes event inputs are one-cycle pulses.
module sport_irq_ctrl
    import sport_irq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              shifter_busy,
    input  logic              eot_mode,
    input  logic              tx_dma_done,
    input  logic              rx_dma_done,
    input  logic              rx_overrun,
    input  logic              rx_timeout,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic                tx_flag;
    logic                rx_flag;
    logic                eot_pulse;
    logic [N_STICKY-1:0] st_set;
    logic [N_STICKY-1:0] st_clr;
    logic [N_STICKY-1:0] st_q;
    stat_t               clr_w;
    stat_t               raw;

    sport_irq_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_level     (tx_level),
        .rx_level     (rx_level),
        .shifter_busy (shifter_busy),
        .eot_mode     (eot_mode),
        .tx_flag_q    (tx_flag),
        .rx_flag_q    (rx_flag),
        .eot_pulse    (eot_pulse)
    );

    // route events into the sticky vector
    always_comb begin
        st_set        = '0;
        st_set[S_OVR] = rx_overrun;
        st_set[S_TMO] = rx_timeout;
        st_set[S_RXD] = rx_dma_done;
        st_set[S_TXD] = tx_dma_done;
        st_set[S_EOT] = eot_pulse;
    end

    // route clear bits; level bits have no clear path
    always_comb begin
        st_clr        = '0;
        st_clr[S_OVR] = clr_w[B_OVR];
        st_clr[S_TMO] = clr_w[B_TMO];
        st_clr[S_RXD] = clr_w[B_RXD];
        st_clr[S_TXD] = clr_w[B_TXD];
        st_clr[S_EOT] = clr_w[B_EOT];
    end

    sport_irq_sticky #(.N(N_STICKY)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (st_set),
        .clr_i (st_clr),
        .q_o   (st_q)
    );

    // assemble the raw word in software bit order
    always_comb begin
        raw        = '0;
        raw[B_OVR] = st_q[S_OVR];
        raw[B_TMO] = st_q[S_TMO];
        raw[B_RXL] = rx_flag;
        raw[B_TXL] = tx_flag;
        raw[B_RXD] = st_q[S_RXD];
        raw[B_TXD] = st_q[S_TXD];
        raw[B_EOT] = st_q[S_EOT];
    end

    sport_irq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .raw_i     (raw),
        .clr_o     (clr_w),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    AST_EOT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[B_EOT]) |-> ($past(tx_level) == '0 && !$past(shifter_busy))); // R5
    AST_LEVEL_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= LVL_W'(DEPTH / 2) && clr_w[B_RXL]) |=> raw[B_RXL]); // R9
endmodule

// File: tb/sim_sport_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sport_irq_ctrl;
    localparam int DEPTH = 8;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int HALF  = DEPTH / 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [LVL_W-1:0] tx_level;
    logic [LVL_W-1:0] rx_level;
    logic             shifter_busy;
    logic             eot_mode;
    logic             tx_dma_done;
    logic             rx_dma_done;
    logic             rx_overrun;
    logic             rx_timeout;
    logic [1:0]       reg_addr;
    logic             reg_wr;
    logic [31:0]      reg_wdata;
    logic [31:0]      reg_rdata;
    logic             irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sport_irq_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
        .shifter_busy(shifter_busy), .eot_mode(eot_mode),
        .tx_dma_done(tx_dma_done), .rx_dma_done(rx_dma_done),
        .rx_overrun(rx_overrun), .rx_timeout(rx_timeout),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick();
        reg_wr    = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [6:0]  raw_exp;
        rst_n = 1'b0; tx_level = '0; rx_level = '0; shifter_busy = 1'b0;
        eot_mode = 1'b0; tx_dma_done = 1'b0; rx_dma_done = 1'b0;
        rx_overrun = 1'b0; rx_timeout = 1'b0; reg_addr = '0; reg_wr = 1'b0;
        reg_wdata = '0;
        repeat (3) tick();
        rd(2'd0, d); chk("R1 reset raw", d, 32'h08);
        rd(2'd1, d); chk("R10 reset mask", d, 32'h0);
        chk("R11 reset irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        tick();
        rd(2'd0, d); chk("R5 no event from reset idle", d, 32'h08);

        // level sweep over every combination of mode, levels and busy
        for (int m = 0; m < 2; m++)
            for (int t = 0; t <= DEPTH; t++)
                for (int r = 0; r <= DEPTH; r++)
                    for (int b = 0; b < 2; b++) begin
                        eot_mode = m[0]; tx_level = LVL_W'(t);
                        rx_level = LVL_W'(r); shifter_busy = b[0];
                        tick();
                        rd(2'd0, d);
                        if (m == 0) chk("R2 tx level", {31'd0, d[3]}, {31'd0, t <= HALF});
                        else        chk("R3 eot mode tx", {31'd0, d[3]}, {31'd0, (t == 0) && (b == 0)});
                        chk("R4 rx level", {31'd0, d[2]}, {31'd0, r >= HALF});
                        chk("R12 upper zero", {25'd0, d[31:7]}, 32'd0);
                    end

        // end-of-transmit edge behaviour
        eot_mode = 1'b0; rx_level = '0; tx_level = 4'd3; shifter_busy = 1'b1;
        tick();
        wr(2'd3, 32'h7F);
        rd(2'd0, d); chk("R5 cleared", {31'd0, d[6]}, 32'd0);
        tx_level = '0; tick();
        rd(2'd0, d); chk("R5 still busy", {31'd0, d[6]}, 32'd0);
        shifter_busy = 1'b0; tick();
        rd(2'd0, d); chk("R5 set on idle", {31'd0, d[6]}, 32'd1);
        tick();
        rd(2'd0, d); chk("R5 holds", {31'd0, d[6]}, 32'd1);
        wr(2'd3, 32'h40);
        rd(2'd0, d); chk("R5 clear", {31'd0, d[6]}, 32'd0);
        tick(); tick();
        rd(2'd0, d); chk("R5 no repeat while idle", {31'd0, d[6]}, 32'd0);
        shifter_busy = 1'b1; tick(); shifter_busy = 1'b0; tick();
        rd(2'd0, d); chk("R5 second transfer", {31'd0, d[6]}, 32'd1);
        wr(2'd3, 32'h40);

        // sticky events: set, hold, clear one at a time
        tx_level = 4'd5;
        tick();
        for (int k = 0; k < 4; k++) begin
            int bitpos;
            bitpos = (k < 2) ? k : k + 2;
            rx_overrun = (k == 0); rx_timeout = (k == 1);
            rx_dma_done = (k == 2); tx_dma_done = (k == 3);
            tick();
            rx_overrun = 1'b0; rx_timeout = 1'b0; rx_dma_done = 1'b0; tx_dma_done = 1'b0;
            tick();
            rd(2'd0, d);
            if (k < 2) chk("R7 sticky set", d, 32'h1 << bitpos);
            else       chk("R6 dma sticky set", d, 32'h1 << bitpos);
            wr(2'd3, ~(32'h1 << bitpos));
            rd(2'd0, d);
            if (k < 2) chk("R7 other clears leave it", d, 32'h1 << bitpos);
            else       chk("R6 other clears leave it", d, 32'h1 << bitpos);
            wr(2'd3, 32'h1 << bitpos);
            rd(2'd0, d);
            if (k < 2) chk("R7 cleared", d, 32'h0);
            else       chk("R6 cleared", d, 32'h0);
        end

        // set and clear in the same cycle: set wins
        rx_overrun = 1'b1; rx_timeout = 1'b1; rx_dma_done = 1'b1; tx_dma_done = 1'b1;
        wr(2'd3, 32'h7F);
        rx_overrun = 1'b0; rx_timeout = 1'b0; rx_dma_done = 1'b0; tx_dma_done = 1'b0;
        rd(2'd0, d); chk("R8 set beats clear", d, 32'h33);
        wr(2'd3, 32'h7F);

        // clearing level bits does nothing
        tx_level = '0; shifter_busy = 1'b1; rx_level = 4'd8;
        tick();
        wr(2'd3, 32'h0C);
        rd(2'd0, d); chk("R9 level bits unchanged", d, 32'h0C);

        // mask sweep over two raw patterns
        for (int p = 0; p < 2; p++) begin
            if (p == 0) begin
                tx_level = 4'd5; rx_level = '0; shifter_busy = 1'b1;
                tick();
                wr(2'd3, 32'h7F);
                raw_exp = 7'h00;
            end else begin
                tx_level = '0; rx_level = 4'd8; shifter_busy = 1'b0;
                rx_overrun = 1'b1; rx_timeout = 1'b1; rx_dma_done = 1'b1; tx_dma_done = 1'b1;
                tick();
                rx_overrun = 1'b0; rx_timeout = 1'b0; rx_dma_done = 1'b0; tx_dma_done = 1'b0;
                raw_exp = 7'h7F;
            end
            rd(2'd0, d); chk("R1 raw pattern", d, {25'd0, raw_exp});
            for (int mk = 0; mk < 128; mk++) begin
                wr(2'd1, 32'hFFFF_FF80 | mk);
                rd(2'd1, d); chk("R10 mask readback", d, mk);
                rd(2'd2, d); chk("R10 masked status", d, {25'd0, raw_exp & 7'(mk)});
                chk("R11 irq", {31'd0, irq}, {31'd0, |(raw_exp & 7'(mk))});
                rd(2'd3, d); chk("R12 clear word reads zero", d, 32'd0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule